// File: doc/BRIEF.md
# Flexible Serial Shift and Count Core

This block is the datapath of a small, general-purpose serial port. An 8-bit shift register moves one place toward the MSB on each selected clock event, taking the serial input at the LSB and presenting its MSB on the serial output. The host reads and writes that register directly; there is no holding copy. Next to it, a 4-bit event counter advances on the same clock source and raises an overflow flag when it wraps. Three clock sources can be selected: a software strobe, a timer compare-match pulse, or an edge of the external serial clock. With the external clock the counter counts both edges, so a counter preloaded to its top value turns the overflow flag into an extra external interrupt line.

When the wire-mode field selects two-wire operation, the block also recognises a bus start condition and asks for the serial clock line to be held low until the host has dealt with the event. This behaviour comes from a three-state machine. State `TW_OFF` applies outside two-wire mode. It moves to `TW_RUN` when two-wire mode is selected. `TW_RUN` moves to `TW_HOLD` on a start detection or a counter overflow. `TW_HOLD` moves back to `TW_RUN` once both the start flag and the overflow flag are clear. Either `TW_RUN` or `TW_HOLD` drops to `TW_OFF` when the mode is left. The hold request is high only in `TW_HOLD`.

Both serial inputs pass through a two-flop synchronizer, and edges are detected after it. The external clock must therefore run at no more than a quarter of the system clock.

Top module: `fsc_core`

## Requirements
- R1: After reset, the shift register, counter, both flags, the control fields, `irq`, `ser_dout` and `scl_hold` are all 0.
- R2: Each selected shift event moves the register left by one, with the synchronized serial input entering bit 0. `ser_dout` always shows bit 7. The register is read and written at host address 0.
- R3: A host write to address 0 in the same cycle as a shift event loads the written value and drops that shift. The counter still advances on that event.
- R4: Control field bits [3:2] select the source. 00 is the software strobe (writing control with bit 1 set). 01 is the `tmr_match` pulse. 10 is an external rising edge. 11 is an external falling edge. Events from an unselected source change neither the register nor the counter.
- R5: With source 10 or 11, the counter increments on both edges of `ser_clk_in`, while the shift happens only on the selected edge. With source 00 or 01, the counter increments once per event.
- R6: Status is at address 1. Bit 6 is the overflow flag and bits [3:0] are the counter. On a count event at 0xF, the counter wraps to 0 and the flag is set. Writing 1 to bit 6 clears the flag. `irq` is high while the flag is set and control bit 6 (overflow enable) is 1.
- R7: A counter preloaded to 0xF with an external source overflows on the very next external edge, raising `irq` when enabled.
- R8: With wire mode 00 (control bits [5:4]), the external clock and data inputs still shift and count.
- R9: Only in two-wire mode (bits [5:4] = 10), a falling edge on the synchronized data line while the synchronized clock is high sets status bit 7. The flag is sticky and is cleared by writing 1 to it. A data fall while the clock is low does not set it. `irq` is also high while bit 7 and control bit 7 are both set.
- R10: In two-wire mode, `scl_hold` rises after a start detection or an overflow and falls once both flags are clear. Outside two-wire mode it stays low.
- R11: A host write to address 1 loads the counter from data bits [3:0], and that load wins over a same-cycle count event. Control at address 2 reads back bits [7:2], with bits 1 and 0 reading as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 2 | Register select: 0 data, 1 status, 2 control |
| host_wr | input | 1 | Host write enable, one cycle per write |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for the selected register |
| ser_din | input | 1 | Serial data input (data line in two-wire mode) |
| ser_clk_in | input | 1 | External serial clock input |
| tmr_match | input | 1 | Timer compare-match pulse, one system clock wide |
| ser_dout | output | 1 | Serial data output, register MSB |
| scl_hold | output | 1 | Request to hold the serial clock line low |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a host write to the data register landing in exactly the same cycle as a shift event. An external clock edge is delayed by the synchronizer, so it cannot be aligned reliably with a host write. The bench therefore selects the timer source and raises `tmr_match` and the host write on the same falling edge of the clock. It then checks that the written byte survives untouched while the counter still advances. The start condition needs a second ordering: the data line must first rise while the clock is low, then the clock must rise, and only then may the data line fall. The bench drives the lines in that order and waits out the synchronizer between steps.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

    typedef enum logic [1:0] {
        TW_OFF  = 2'd0,
        TW_RUN  = 2'd1,
        TW_HOLD = 2'd2
    } tw_state_t;

    typedef enum logic [1:0] {
        SRC_STROBE   = 2'd0,
        SRC_TIMER    = 2'd1,
        SRC_EXT_RISE = 2'd2,
        SRC_EXT_FALL = 2'd3
    } clk_src_t;

    localparam int        ADDR_W     = 2;
    localparam logic [1:0] ADDR_DATA = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_CTRL = 2'd2;

    localparam logic [1:0] WM_TWO    = 2'b10;

    // control register bit positions
    localparam int CTL_STIE   = 7;
    localparam int CTL_OVIE   = 6;
    localparam int CTL_WM_LO  = 4;
    localparam int CTL_SRC_LO = 2;
    localparam int CTL_STROBE = 1;

    // status register bit positions
    localparam int ST_START = 7;
    localparam int ST_OVF   = 6;

endpackage

// File: rtl/fsc_sync.sv
module fsc_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] lvl,
    output logic [W-1:0] lvl_d
);

    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
            lvl_d <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], async_in};
            lvl_d <= chain[STAGES-1];
        end
    end

    assign lvl = chain[STAGES-1];

endmodule

// File: rtl/fsc_tw_fsm.sv
module fsc_tw_fsm
    import fsc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tw_mode,
    input  logic hold_req,
    input  logic flags_pending,
    output logic scl_hold
);

    tw_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TW_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TW_OFF: begin
                if (tw_mode) state_d = TW_RUN;
            end
            TW_RUN: begin
                if (!tw_mode)      state_d = TW_OFF;
                else if (hold_req) state_d = TW_HOLD;
            end
            TW_HOLD: begin
                if (!tw_mode)                         state_d = TW_OFF;
                else if (!flags_pending && !hold_req) state_d = TW_RUN;
            end
            default: state_d = TW_OFF;
        endcase
    end

    always_comb begin
        scl_hold = (state_q == TW_HOLD);
    end

endmodule

// File: rtl/fsc_core.sv
module fsc_core
    import fsc_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int CNT_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              ser_din,
    input  logic              ser_clk_in,
    input  logic              tmr_match,
    output logic              ser_dout,
    output logic              scl_hold,
    output logic              irq
);

    localparam int PAD_W = DATA_W - CNT_W - 2;

    // synchronized serial lines: bit 0 data, bit 1 clock
    logic [1:0] line_s, line_d;
    logic       din_s, clk_s, clk_rise, clk_fall, din_fall;

    fsc_sync #(.W(2), .STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({ser_clk_in, ser_din}),
        .lvl      (line_s),
        .lvl_d    (line_d)
    );

    assign din_s    = line_s[0];
    assign clk_s    = line_s[1];
    assign clk_rise =  line_s[1] & ~line_d[1];
    assign clk_fall = ~line_s[1] &  line_d[1];
    assign din_fall = ~line_s[0] &  line_d[0];

    // host decode
    logic wr_data, wr_stat, wr_ctrl, strobe;
    assign wr_data = host_wr && (host_addr == ADDR_DATA);
    assign wr_stat = host_wr && (host_addr == ADDR_STAT);
    assign wr_ctrl = host_wr && (host_addr == ADDR_CTRL);
    assign strobe  = wr_ctrl && host_wdata[CTL_STROBE];

    // control fields
    logic     st_ie, ov_ie;
    logic [1:0] wire_mode;
    clk_src_t clk_src;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_ie     <= 1'b0;
            ov_ie     <= 1'b0;
            wire_mode <= 2'b00;
            clk_src   <= SRC_STROBE;
        end else if (wr_ctrl) begin
            st_ie     <= host_wdata[CTL_STIE];
            ov_ie     <= host_wdata[CTL_OVIE];
            wire_mode <= host_wdata[CTL_WM_LO +: 2];
            clk_src   <= clk_src_t'(host_wdata[CTL_SRC_LO +: 2]);
        end
    end

    // event selection
    logic shift_evt, cnt_evt;
    always_comb begin
        unique case (clk_src)
            SRC_STROBE:   begin shift_evt = strobe;    cnt_evt = strobe;    end
            SRC_TIMER:    begin shift_evt = tmr_match; cnt_evt = tmr_match; end
            SRC_EXT_RISE: begin shift_evt = clk_rise;  cnt_evt = clk_rise | clk_fall; end
            SRC_EXT_FALL: begin shift_evt = clk_fall;  cnt_evt = clk_rise | clk_fall; end
            default:      begin shift_evt = 1'b0;      cnt_evt = 1'b0;      end
        endcase
    end

    // shift register: host write beats shift
    logic [DATA_W-1:0] sr_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         sr_q <= '0;
        else if (wr_data)   sr_q <= host_wdata;
        else if (shift_evt) sr_q <= {sr_q[DATA_W-2:0], din_s};
    end

    // edge counter and overflow
    logic [CNT_W-1:0] cnt_q;
    logic             ovf_evt, ovf_flag;
    assign ovf_evt = cnt_evt && !wr_stat && (cnt_q == {CNT_W{1'b1}});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (wr_stat) cnt_q <= host_wdata[CNT_W-1:0];
        else if (cnt_evt) cnt_q <= cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               ovf_flag <= 1'b0;
        else if (ovf_evt)                         ovf_flag <= 1'b1;
        else if (wr_stat && host_wdata[ST_OVF])   ovf_flag <= 1'b0;
    end

    // two-wire start condition
    logic tw_mode, start_det, start_flag;
    assign tw_mode   = (wire_mode == WM_TWO);
    assign start_det = tw_mode && clk_s && din_fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               start_flag <= 1'b0;
        else if (start_det)                       start_flag <= 1'b1;
        else if (wr_stat && host_wdata[ST_START]) start_flag <= 1'b0;
    end

    fsc_tw_fsm tw_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .tw_mode       (tw_mode),
        .hold_req      (start_det | ovf_evt),
        .flags_pending (start_flag | ovf_flag),
        .scl_hold      (scl_hold)
    );

    // outputs
    assign ser_dout = sr_q[DATA_W-1];
    assign irq      = (ovf_flag && ov_ie) || (start_flag && st_ie);

    always_comb begin
        unique case (host_addr)
            ADDR_DATA: host_rdata = sr_q;
            ADDR_STAT: host_rdata = {start_flag, ovf_flag, {PAD_W{1'b0}}, cnt_q};
            ADDR_CTRL: host_rdata = {st_ie, ov_ie, wire_mode, clk_src, 2'b00};
            default:   host_rdata = '0;
        endcase
    end

endmodule

// File: rtl/fsc_core_chk.sv
module fsc_core_chk #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_data,
    input logic              wr_stat,
    input logic [DATA_W-1:0] host_wdata,
    input logic              shift_evt,
    input logic              cnt_evt,
    input logic              din_s,
    input logic [DATA_W-1:0] sr_q,
    input logic [CNT_W-1:0]  cnt_q,
    input logic              ovf_flag,
    input logic              start_flag,
    input logic [1:0]        wire_mode,
    input logic              scl_hold
);

    a_r2_shift_left: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_evt && !wr_data) |=> (sr_q == {$past(sr_q[DATA_W-2:0]), $past(din_s)}));

    a_r3_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data |=> (sr_q == $past(host_wdata)));

    a_r5_cnt_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_stat && !cnt_evt) |=> $stable(cnt_q));

    a_r6_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_evt && !wr_stat && (cnt_q == {CNT_W{1'b1}})) |=> (ovf_flag && (cnt_q == '0)));

    a_r9_start_tw_only: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_flag) |-> ($past(wire_mode) == 2'b10));

    a_r10_no_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
        (wire_mode != 2'b10) |=> !scl_hold);

    a_r10_hold_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_hold) |-> (ovf_flag || start_flag));

    a_r11_cnt_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat |=> (cnt_q == $past(host_wdata[CNT_W-1:0])));

endmodule

bind fsc_core fsc_core_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_data    (wr_data),
    .wr_stat    (wr_stat),
    .host_wdata (host_wdata),
    .shift_evt  (shift_evt),
    .cnt_evt    (cnt_evt),
    .din_s      (din_s),
    .sr_q       (sr_q),
    .cnt_q      (cnt_q),
    .ovf_flag   (ovf_flag),
    .start_flag (start_flag),
    .wire_mode  (wire_mode),
    .scl_hold   (scl_hold)
);

// File: tb/fsc_core_tb_top.sv
module fsc_core_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] host_addr = 2'd0;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic       ser_din = 1'b0;
    logic       ser_clk_in = 1'b0;
    logic       tmr_match = 1'b0;
    logic       ser_dout, scl_hold, irq;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    fsc_core dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_addr  (host_addr),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .ser_din    (ser_din),
        .ser_clk_in (ser_clk_in),
        .tmr_match  (tmr_match),
        .ser_dout   (ser_dout),
        .scl_hold   (scl_hold),
        .irq        (irq)
    );

    localparam logic [1:0] A_DATA = 2'd0, A_STAT = 2'd1, A_CTRL = 2'd2;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic hwrite(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hread(input logic [1:0] a, output logic [7:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic chk_reg(input string tag, input logic [1:0] a, input logic [7:0] exp);
        logic [7:0] v;
        hread(a, v);
        chk(tag, v, exp);
    endtask

    task automatic scl_set(input logic v);
        @(negedge clk);
        ser_clk_in = v;
        wait_cyc(4);
    endtask

    task automatic din_set(input logic v);
        @(negedge clk);
        ser_din = v;
        wait_cyc(4);
    endtask

    task automatic tmr_pulse();
        @(negedge clk);
        tmr_match = 1'b1;
        @(negedge clk);
        tmr_match = 1'b0;
    endtask

    task automatic t_reset();
        chk_reg("R1 data", A_DATA, 8'h00);
        chk_reg("R1 status", A_STAT, 8'h00);
        chk_reg("R1 control", A_CTRL, 8'h00);
        chk("R1 irq", {7'b0, irq}, 8'h00);
        chk("R1 hold", {7'b0, scl_hold}, 8'h00);
        chk("R1 dout", {7'b0, ser_dout}, 8'h00);
    endtask

    task automatic t_strobe_shift();
        hwrite(A_DATA, 8'h81);
        chk("R2 dout msb", {7'b0, ser_dout}, 8'h01);
        din_set(1'b1);
        hwrite(A_CTRL, 8'h02);
        chk_reg("R2 shift in 1", A_DATA, 8'h03);
        chk_reg("R2 count", A_STAT, 8'h01);
        din_set(1'b0);
        hwrite(A_CTRL, 8'h02);
        chk_reg("R2 shift in 0", A_DATA, 8'h06);
        chk("R2 dout low", {7'b0, ser_dout}, 8'h00);
        chk_reg("R11 ctrl readback", A_CTRL, 8'h00);
    endtask

    task automatic t_source_select();
        tmr_pulse();
        scl_set(1'b1);
        scl_set(1'b0);
        chk_reg("R4 unselected data", A_DATA, 8'h06);
        chk_reg("R4 unselected count", A_STAT, 8'h02);
        hwrite(A_CTRL, 8'h04);
        hwrite(A_CTRL, 8'h06);
        chk_reg("R4 strobe ignored on timer", A_DATA, 8'h06);
        tmr_pulse();
        chk_reg("R4 timer shift", A_DATA, 8'h0C);
        chk_reg("R4 timer count", A_STAT, 8'h03);
    endtask

    task automatic t_collide();
        @(negedge clk);
        host_addr = A_DATA; host_wdata = 8'h5A; host_wr = 1'b1; tmr_match = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; tmr_match = 1'b0;
        chk_reg("R3 write wins", A_DATA, 8'h5A);
        chk_reg("R3 count advances", A_STAT, 8'h04);
    endtask

    task automatic t_external();
        hwrite(A_CTRL, 8'h08);
        hwrite(A_DATA, 8'h00);
        hwrite(A_STAT, 8'h00);
        din_set(1'b1);
        scl_set(1'b1);
        chk_reg("R8 rise shift mode 00", A_DATA, 8'h01);
        chk_reg("R5 rise counted", A_STAT, 8'h01);
        scl_set(1'b0);
        chk_reg("R5 fall no shift", A_DATA, 8'h01);
        chk_reg("R5 fall counted", A_STAT, 8'h02);
        hwrite(A_CTRL, 8'h0C);
        scl_set(1'b1);
        chk_reg("R5 rise counted fall-src", A_STAT, 8'h03);
        din_set(1'b0);
        scl_set(1'b0);
        chk_reg("R4 fall-edge shift", A_DATA, 8'h02);
        chk_reg("R5 both edges", A_STAT, 8'h04);
    endtask

    task automatic t_overflow();
        hwrite(A_CTRL, 8'h40);
        hwrite(A_STAT, 8'h0E);
        hwrite(A_CTRL, 8'h42);
        chk_reg("R6 at top", A_STAT, 8'h0F);
        chk("R6 no irq yet", {7'b0, irq}, 8'h00);
        hwrite(A_CTRL, 8'h42);
        chk_reg("R6 wrap flag", A_STAT, 8'h40);
        chk("R6 irq on", {7'b0, irq}, 8'h01);
        hwrite(A_CTRL, 8'h00);
        chk("R6 irq masked", {7'b0, irq}, 8'h00);
        chk_reg("R6 flag kept", A_STAT, 8'h40);
        hwrite(A_CTRL, 8'h40);
        hwrite(A_STAT, 8'h40);
        chk_reg("R6 w1c", A_STAT, 8'h00);
        chk("R6 irq off", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_ext_interrupt();
        hwrite(A_CTRL, 8'h48);
        hwrite(A_STAT, 8'h0F);
        scl_set(1'b1);
        chk_reg("R7 one edge overflow", A_STAT, 8'h40);
        chk("R7 irq", {7'b0, irq}, 8'h01);
        hwrite(A_STAT, 8'h40);
        scl_set(1'b0);
        chk_reg("R7 next edge counts", A_STAT, 8'h01);
    endtask

    task automatic t_start();
        hwrite(A_CTRL, 8'h80);
        din_set(1'b1);
        scl_set(1'b1);
        din_set(1'b0);
        chk_reg("R9 no start mode 00", A_STAT, 8'h01);
        chk("R9 no irq mode 00", {7'b0, irq}, 8'h00);
        scl_set(1'b0);
        hwrite(A_CTRL, 8'hA0);
        din_set(1'b1);
        scl_set(1'b1);
        din_set(1'b0);
        chk_reg("R9 start flag", A_STAT, 8'h81);
        chk("R9 start irq", {7'b0, irq}, 8'h01);
        chk("R10 hold on start", {7'b0, scl_hold}, 8'h01);
        hwrite(A_STAT, 8'h80);
        wait_cyc(2);
        chk_reg("R9 start w1c", A_STAT, 8'h00);
        chk("R10 hold released", {7'b0, scl_hold}, 8'h00);
        scl_set(1'b0);
        din_set(1'b1);
        din_set(1'b0);
        chk_reg("R9 fall with clock low", A_STAT, 8'h00);
    endtask

    task automatic t_tw_overflow();
        hwrite(A_CTRL, 8'h28);
        hwrite(A_STAT, 8'h0F);
        chk("R10 idle no hold", {7'b0, scl_hold}, 8'h00);
        scl_set(1'b1);
        chk_reg("R10 overflow flag", A_STAT, 8'h40);
        chk("R10 hold on overflow", {7'b0, scl_hold}, 8'h01);
        hwrite(A_STAT, 8'h40);
        wait_cyc(2);
        chk("R10 hold cleared", {7'b0, scl_hold}, 8'h00);
        scl_set(1'b0);
        hwrite(A_CTRL, 8'h18);
        hwrite(A_STAT, 8'h0F);
        scl_set(1'b1);
        chk_reg("R10 three-wire overflow", A_STAT, 8'h40);
        chk("R10 no hold three-wire", {7'b0, scl_hold}, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        wait_cyc(2);
        t_reset();
        t_strobe_shift();
        t_source_select();
        t_collide();
        t_external();
        t_overflow();
        t_ext_interrupt();
        t_start();
        t_tw_overflow();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule